// File: doc/BRIEF.md
# Controller Command/Result Handshake Sequencer

This block sits on the host side of a byte-wide disk-controller register interface. A local requester hands it a command of one to `MAX_CMD` bytes and the number of result bytes it expects. The block polls the controller's main status byte and pushes the command bytes, one at a time, into the controller's data FIFO. When results are expected, it waits for the controller to turn the bus around and then pulls the result bytes back out.

Before every status sample the block waits a short settle interval, because the ready flag is not valid straight after a FIFO access. Each byte has a bounded poll window. A poll that runs out is retried, and the fourth expiry in one phase is fatal. The request ends with a one-cycle done pulse and a two-bit error code. The result bytes are returned as a flat vector. The first command byte is kept as the current operation mode, so that interrupt logic elsewhere can read it.

Timing is counted in ticks of a 1 us strobe supplied by the surrounding logic. The settle interval and every timeout are parameters.

Top module: `cmdres_handshake`

## Requirements
- R1: After reset `done_o`, `busy_o`, `fifo_wr_o` and `fifo_rd_o` are 0, `err_o` is 0 (no error) and `res_count_o` is 0.
- R2: No status sample happens until `SETTLE_US` ticks have passed since the previous step. The first FIFO write therefore comes at least 2×`SETTLE_US` ticks after start: one settle before the opening check and one before the byte. Consecutive writes are at least `SETTLE_US` ticks apart.
- R3: A command byte is written only while status bit 7 (ready) is 1 and bit 6 (direction, 1 = controller-to-host) is 0. The bytes go out in array order, byte 0 first, taken from `cmd_bytes_i[8*i+7:8*i]`.
- R4: If the opening status check after start does not show ready with direction 0, the request ends with error code 1 (busy) and no byte is written.
- R5: A command or result byte whose `CMD_TO_US`/`RES_TO_US` tick poll window runs out is retried after a fresh settle. The fourth expiry within one phase ends the request with error code 2 (timeout).
- R6: When results are expected, the block waits after the last command byte for up to `OUT_TO_US` ticks for ready with direction 1. If that wait runs out, the request ends with error code 2 at once, with no retry and no read.
- R7: In the cycle after the ready-for-output wait succeeds, the status is checked again. If it no longer shows ready with direction 1, the request ends with error code 1 and nothing is read.
- R8: During the result phase, if the controller shows ready with direction 1 but status bit 4 (controller busy) is 0 before all expected bytes are read, the request ends with error code 3 (premature end) and no further read.
- R9: Result bytes are stored in read order at `res_bytes_o[8*i+7:8*i]`, and `res_count_o` gives how many were read. A request with zero expected results finishes right after its last command byte with error code 0.
- R10: After the last result byte is read, `done_o` is held off for one more settle interval.
- R11: `op_mode_o` takes the first command byte once the opening check passes. A request rejected as busy leaves it unchanged.
- R12: `busy_o` is high from the cycle after start until the request ends. `done_o` is a single-cycle pulse. `err_o` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| start_i | input | 1 | Start a request (taken only when idle) |
| cmd_bytes_i | input | 8*MAX_CMD | Command bytes, byte 0 in the low octet |
| cmd_len_i | input | $clog2(MAX_CMD+1) | Number of command bytes, 1..MAX_CMD |
| res_len_i | input | $clog2(MAX_RES+1) | Number of result bytes expected |
| status_i | input | 8 | Controller main status byte |
| fifo_wr_o | output | 1 | Write strobe to the controller data FIFO |
| fifo_wdata_o | output | 8 | Byte written to the FIFO |
| fifo_rd_o | output | 1 | Read strobe from the controller data FIFO |
| fifo_rdata_i | input | 8 | Byte presented by the FIFO |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Request finished (one cycle) |
| err_o | output | 2 | 0 none, 1 busy, 2 timeout, 3 premature end |
| res_bytes_o | output | 8*MAX_RES | Result bytes in read order |
| res_count_o | output | $clog2(MAX_RES+1) | Result bytes read |
| op_mode_o | output | 8 | First byte of the last accepted command |

## Verification
The hardest case to reach is the busy error at the start of the result phase. The ready-for-output wait has just seen the right status, and that status must be gone one cycle later. The bench controller model holds the status at not-ready for long enough to cover the settle that comes before that wait. It then shows ready-for-output for exactly one clock edge and drops back to ready-for-input. Retries are driven the same way: the model stalls a chosen byte for long enough to cost two poll windows, and in a second case for long enough to cost four.

// File: rtl/hsk_pkg.sv
// Shared types for the command/result handshake sequencer.
// Assumes an 8-bit controller status byte with fixed flag positions.
package hsk_pkg;

    // Completion codes reported on err_o
    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_BUSY    = 2'd1,
        ERR_TIMEOUT = 2'd2,
        ERR_EARLY   = 2'd3
    } hsk_err_e;

    // Sequencer states
    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_OPEN,
        S_CSET,
        S_CPOLL,
        S_OSET,
        S_OPOLL,
        S_RCHK,
        S_RSET,
        S_RPOLL,
        S_FSET
    } hsk_state_e;

    // Status flag positions
    localparam int RQM_BIT   = 7;
    localparam int DIR_BIT   = 6;
    localparam int CBUSY_BIT = 4;

endpackage

// File: rtl/hsk_status_decode.sv
// Decodes the controller status byte into the three conditions the
// sequencer acts on. Purely combinational; assumes the byte is stable
// around the sampling edge.
module hsk_status_decode
    import hsk_pkg::*;
(
    input  logic [7:0] status,
    output logic       in_rdy,
    output logic       out_rdy,
    output logic       ctl_busy
);

    logic unused_bits;

    // ready and direction combine into the two transfer conditions
    always_comb begin
        in_rdy   = status[RQM_BIT] && !status[DIR_BIT];
        out_rdy  = status[RQM_BIT] &&  status[DIR_BIT];
        ctl_busy = status[CBUSY_BIT];
    end

    assign unused_bits = ^{status[5], status[3:0]};

endmodule

// File: rtl/hsk_us_timer.sv
// Microsecond interval counter shared by settle waits and poll windows.
// Counts tick strobes from a clear, saturating at MAX_COUNT.
module hsk_us_timer #(
    parameter  int MAX_COUNT = 500,
    localparam int TW        = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [TW-1:0] count
);

    localparam logic [TW-1:0] TOP = TW'(MAX_COUNT);

    // restart on clear, advance once per tick, hold at the top
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (tick && count != TOP) begin
            count <= count + TW'(1);
        end
    end

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP);

endmodule

// File: rtl/hsk_result_bank.sv
// Register bank holding result bytes in read order. Cleared when a new
// request starts; one entry written per read strobe.
module hsk_result_bank #(
    parameter  int DEPTH = 10,
    localparam int IW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [IW-1:0]    idx,
    input  logic [7:0]       wdata,
    output logic [8*DEPTH-1:0] flat
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [7:0] ent_q;

        // capture the byte aimed at this slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                ent_q <= '0;
            end else if (we && idx == IW'(g)) begin
                ent_q <= wdata;
            end
        end

        assign flat[8*g +: 8] = ent_q;
    end

endmodule

// File: rtl/cmdres_handshake.sv
// Command/result handshake sequencer. Writes a command byte string into
// a controller FIFO under status polling and reads back result bytes.
// Assumes status_i and fifo_rdata_i are stable around each clock edge
// and that tick_us is a one-cycle strobe once per microsecond.
module cmdres_handshake
    import hsk_pkg::*;
#(
    parameter  int MAX_CMD   = 9,
    parameter  int MAX_RES   = 10,
    parameter  int SETTLE_US = 12,
    parameter  int CMD_TO_US = 150,
    parameter  int OUT_TO_US = 500,
    parameter  int RES_TO_US = 150,
    parameter  int RETRIES   = 3,
    localparam int CLW       = $clog2(MAX_CMD + 1),
    localparam int RLW       = $clog2(MAX_RES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_us,
    input  logic                 start_i,
    input  logic [8*MAX_CMD-1:0] cmd_bytes_i,
    input  logic [CLW-1:0]       cmd_len_i,
    input  logic [RLW-1:0]       res_len_i,
    input  logic [7:0]           status_i,
    output logic                 fifo_wr_o,
    output logic [7:0]           fifo_wdata_o,
    output logic                 fifo_rd_o,
    input  logic [7:0]           fifo_rdata_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [1:0]           err_o,
    output logic [8*MAX_RES-1:0] res_bytes_o,
    output logic [RLW-1:0]       res_count_o,
    output logic [7:0]           op_mode_o
);

    localparam int TMAX_A = (CMD_TO_US > RES_TO_US) ? CMD_TO_US : RES_TO_US;
    localparam int TMAX_B = (OUT_TO_US > TMAX_A) ? OUT_TO_US : TMAX_A;
    localparam int TMAX   = (SETTLE_US > TMAX_B) ? SETTLE_US : TMAX_B;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int RTW    = $clog2(RETRIES + 2);

    localparam logic [TW-1:0]  SET_L = TW'(SETTLE_US);
    localparam logic [TW-1:0]  CTO_L = TW'(CMD_TO_US);
    localparam logic [TW-1:0]  OTO_L = TW'(OUT_TO_US);
    localparam logic [TW-1:0]  RTO_L = TW'(RES_TO_US);
    localparam logic [RTW-1:0] RT_L  = RTW'(RETRIES);

    hsk_state_e       state_q, state_d;
    hsk_err_e         err_q, fin_code;
    logic [7:0]       cmd_q [MAX_CMD];
    logic [CLW-1:0]   clen_q, idx_q;
    logic [RLW-1:0]   rlen_q, ridx_q;
    logic [RTW-1:0]   retry_q;
    logic [7:0]       op_q;
    logic             done_q;
    logic             in_rdy, out_rdy, ctl_busy;
    logic [TW-1:0]    tmr_cnt;
    logic             accept, settled, cmd_last, res_last;
    logic             wr, rd, finish, retry_inc, retry_clr, open_ok;

    hsk_status_decode u_dec (
        .status   (status_i),
        .in_rdy   (in_rdy),
        .out_rdy  (out_rdy),
        .ctl_busy (ctl_busy)
    );

    hsk_us_timer #(.MAX_COUNT(TMAX)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .tick  (tick_us),
        .count (tmr_cnt)
    );

    hsk_result_bank #(.DEPTH(MAX_RES)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .we    (rd),
        .idx   (ridx_q),
        .wdata (fifo_rdata_i),
        .flat  (res_bytes_o)
    );

    // shared conditions for the state decision
    always_comb begin
        accept   = start_i && (state_q == S_IDLE);
        settled  = tmr_cnt >= SET_L;
        cmd_last = idx_q == clen_q - CLW'(1);
        res_last = ridx_q == rlen_q - RLW'(1);
    end

    // next state, strobes and completion decision
    always_comb begin
        state_d   = state_q;
        wr        = 1'b0;
        rd        = 1'b0;
        finish    = 1'b0;
        fin_code  = ERR_NONE;
        retry_inc = 1'b0;
        retry_clr = 1'b0;
        open_ok   = 1'b0;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_PRE;
            S_PRE:   if (settled) state_d = S_OPEN;
            S_OPEN: begin
                if (in_rdy) begin
                    open_ok = 1'b1;
                    state_d = S_CSET;
                end else begin
                    finish   = 1'b1;
                    fin_code = ERR_BUSY;
                end
            end
            S_CSET:  if (settled) state_d = S_CPOLL;
            S_CPOLL: begin
                if (in_rdy) begin
                    wr = 1'b1;
                    if (!cmd_last)             state_d = S_CSET;
                    else if (rlen_q == '0)     finish  = 1'b1;
                    else                       state_d = S_OSET;
                end else if (tmr_cnt >= CTO_L) begin
                    if (retry_q == RT_L) begin
                        finish   = 1'b1;
                        fin_code = ERR_TIMEOUT;
                    end else begin
                        retry_inc = 1'b1;
                        state_d   = S_CSET;
                    end
                end
            end
            S_OSET:  if (settled) state_d = S_OPOLL;
            S_OPOLL: begin
                if (out_rdy) begin
                    state_d = S_RCHK;
                end else if (tmr_cnt >= OTO_L) begin
                    finish   = 1'b1;
                    fin_code = ERR_TIMEOUT;
                end
            end
            S_RCHK: begin
                if (out_rdy) begin
                    retry_clr = 1'b1;
                    state_d   = S_RSET;
                end else begin
                    finish   = 1'b1;
                    fin_code = ERR_BUSY;
                end
            end
            S_RSET:  if (settled) state_d = S_RPOLL;
            S_RPOLL: begin
                if (out_rdy) begin
                    if (!ctl_busy) begin
                        finish   = 1'b1;
                        fin_code = ERR_EARLY;
                    end else begin
                        rd      = 1'b1;
                        state_d = res_last ? S_FSET : S_RSET;
                    end
                end else if (tmr_cnt >= RTO_L) begin
                    if (retry_q == RT_L) begin
                        finish   = 1'b1;
                        fin_code = ERR_TIMEOUT;
                    end else begin
                        retry_inc = 1'b1;
                        state_d   = S_RSET;
                    end
                end
            end
            S_FSET:  if (settled) finish = 1'b1;
            default: state_d = S_IDLE;
        endcase
        if (finish) state_d = S_IDLE;
    end

    // state, completion pulse and error code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            done_q  <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (accept)      err_q <= ERR_NONE;
            else if (finish) err_q <= fin_code;
        end
    end

    // request capture, byte indices and retry count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clen_q  <= '0;
            rlen_q  <= '0;
            idx_q   <= '0;
            ridx_q  <= '0;
            retry_q <= '0;
            for (int i = 0; i < MAX_CMD; i++) cmd_q[i] <= '0;
        end else begin
            if (accept) begin
                clen_q <= cmd_len_i;
                rlen_q <= res_len_i;
                idx_q  <= '0;
                ridx_q <= '0;
                for (int i = 0; i < MAX_CMD; i++) cmd_q[i] <= cmd_bytes_i[8*i +: 8];
            end else begin
                if (wr) idx_q  <= idx_q + CLW'(1);
                if (rd) ridx_q <= ridx_q + RLW'(1);
            end
            if (accept || retry_clr) retry_q <= '0;
            else if (retry_inc)      retry_q <= retry_q + RTW'(1);
        end
    end

    // operation mode is the opening byte of an accepted command
    always_ff @(posedge clk) begin
        if (!rst_n)       op_q <= '0;
        else if (open_ok) op_q <= cmd_q[0];
    end

    assign fifo_wr_o    = wr;
    assign fifo_wdata_o = cmd_q[idx_q];
    assign fifo_rd_o    = rd;
    assign busy_o       = state_q != S_IDLE;
    assign done_o       = done_q;
    assign err_o        = err_q;
    assign res_count_o  = ridx_q;
    assign op_mode_o    = op_q;

    // R3
    wr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> (status_i[7:6] == 2'b10));

    // R8
    rd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> (status_i[7:6] == 2'b11 && status_i[4]));

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_wr_o && fifo_rd_o));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R5
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_q <= RT_L);

    // R11
    mode_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_o && idx_q == '0) |-> (op_mode_o == fifo_wdata_o));

endmodule

// File: tb/test_cmdres_handshake.sv
// Bench: a behavioural controller model drives status and read data,
// and every write, read and completion is compared each clock.
module test_cmdres_handshake;

    localparam int MAX_CMD = 9;
    localparam int MAX_RES = 10;
    localparam int SETTLE  = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 tick = 1'b1;
    logic                 start = 1'b0;
    logic [8*MAX_CMD-1:0] cmd_flat = '0;
    logic [3:0]           clen = '0;
    logic [3:0]           rlen = '0;
    logic [7:0]           msr = 8'h80;
    logic [7:0]           rdata = '0;
    logic                 wr_o, rd_o, busy_o, done_o;
    logic [7:0]           wdata_o, op_o;
    logic [1:0]           err_o;
    logic [8*MAX_RES-1:0] res_o;
    logic [3:0]           rcount_o;

    cmdres_handshake i_cmdres_handshake (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_us      (tick),
        .start_i      (start),
        .cmd_bytes_i  (cmd_flat),
        .cmd_len_i    (clen),
        .res_len_i    (rlen),
        .status_i     (msr),
        .fifo_wr_o    (wr_o),
        .fifo_wdata_o (wdata_o),
        .fifo_rd_o    (rd_o),
        .fifo_rdata_i (rdata),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .res_bytes_o  (res_o),
        .res_count_o  (rcount_o),
        .op_mode_o    (op_o)
    );

    always #4 clk = ~clk;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    // controller model state
    logic [7:0] exp_cmd [MAX_CMD];
    logic [7:0] res_vals [MAX_RES];
    int  exp_clen = 0, exp_rlen = 0, wcnt = 0, rcnt = 0;
    int  stall_idx = 99, stall_left = 0, out_dly = 0, prem_at = 99;
    bit  auto_mode = 1, glitch = 0, glitch_done = 0, prev_done = 0;
    logic [7:0] fixed_msr = 8'h80;
    int  tick_div = 1, cyc = 0, done_cnt = 0;
    int  start_cyc = 0, first_wr_cyc = 0, last_wr_cyc = 0, last_rd_cyc = 0, done_cyc = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock compare and controller status model
    initial forever begin
        @(negedge clk); #3;
        if (rst_n && wr_o) begin
            check(wcnt < exp_clen, "R3 extra write", wcnt, exp_clen);
            if (wcnt < exp_clen)
                check(wdata_o == exp_cmd[wcnt], "R3 byte", wdata_o, exp_cmd[wcnt]);
            check(msr[7:6] == 2'b10, "R3 status at write", msr, 8'h90);
            if (wcnt == 0)
                check(cyc - start_cyc >= 2*SETTLE, "R2 first write delay", cyc - start_cyc, 2*SETTLE);
            else
                check(cyc - last_wr_cyc >= SETTLE, "R2 write spacing", cyc - last_wr_cyc, SETTLE);
            last_wr_cyc = cyc;
            wcnt++;
        end
        if (rst_n && rd_o) begin
            check(rcnt < exp_rlen, "R9 extra read", rcnt, exp_rlen);
            last_rd_cyc = cyc;
            rcnt++;
        end
        if (rst_n && done_o) begin
            if (prev_done) check(1'b0, "R12 done width", 2, 1);
            done_cnt++;
            done_cyc = cyc;
        end
        prev_done = done_o;
        @(posedge clk); #1;
        cyc++;
        tick = (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
        if (!auto_mode) msr = fixed_msr;
        else if (wcnt < exp_clen) begin
            if (wcnt == stall_idx && stall_left > 0) begin
                stall_left--;
                msr = 8'h10;
            end else msr = 8'h90;
        end else if (out_dly > 0) begin
            out_dly--;
            msr = 8'h10;
        end else if (glitch) begin
            msr = glitch_done ? 8'h80 : 8'hD0;
            glitch_done = 1;
        end else if (rcnt < exp_rlen) msr = (rcnt == prem_at) ? 8'hC0 : 8'hD0;
        else msr = 8'h80;
        rdata = (rcnt < MAX_RES) ? res_vals[rcnt] : 8'h00;
    end

    task automatic run(input int cl, input int rl);
        @(negedge clk);
        wcnt = 0; rcnt = 0; done_cnt = 0; glitch_done = 0;
        exp_clen = cl; exp_rlen = rl;
        for (int i = 0; i < MAX_CMD; i++) cmd_flat[8*i +: 8] = exp_cmd[i];
        clen = 4'(cl); rlen = 4'(rl);
        start = 1'b1; start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        check(busy_o == 1'b1, "R12 busy after start", busy_o, 1);
        for (int k = 0; k < 5000 && done_cnt == 0; k++) @(negedge clk);
        check(done_cnt == 1, "R12 done seen", done_cnt, 1);
        @(negedge clk);
        check(busy_o == 1'b0, "R12 idle after done", busy_o, 0);
    endtask

    task automatic defaults();
        auto_mode = 1; stall_idx = 99; stall_left = 0; out_dly = 0;
        prem_at = 99; glitch = 0; tick_div = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MAX_CMD; i++) exp_cmd[i] = 8'(8'h31 + i);
        for (int i = 0; i < MAX_RES; i++) res_vals[i] = 8'(i * 17 + 3);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done_o == 0 && busy_o == 0, "R1 done/busy", {done_o, busy_o}, 0);
        check(wr_o == 0 && rd_o == 0, "R1 strobes", {wr_o, rd_o}, 0);
        check(err_o == 0 && rcount_o == 0, "R1 err/count", {err_o, rcount_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // normal three-byte command, two results (R3 R9 R10 R11 R2)
        defaults();
        exp_cmd[0] = 8'h4A; exp_cmd[1] = 8'h01; exp_cmd[2] = 8'h22;
        res_vals[0] = 8'h20; res_vals[1] = 8'h22;
        run(3, 2);
        check(err_o == 0, "R9 err none", err_o, 0);
        check(wcnt == 3, "R3 write count", wcnt, 3);
        check(rcount_o == 2, "R9 count", rcount_o, 2);
        check(res_o[7:0] == 8'h20, "R9 byte0", res_o[7:0], 8'h20);
        check(res_o[15:8] == 8'h22, "R9 byte1", res_o[15:8], 8'h22);
        check(op_o == 8'h4A, "R11 mode", op_o, 8'h4A);
        check(done_cyc - last_rd_cyc >= SETTLE, "R10 final settle", done_cyc - last_rd_cyc, SETTLE);

        // nine bytes, no results (R9 R3)
        defaults();
        exp_cmd[0] = 8'h01;
        for (int i = 1; i < MAX_CMD; i++) exp_cmd[i] = 8'(8'hA0 + i);
        run(9, 0);
        check(err_o == 0, "R9 no-result err", err_o, 0);
        check(wcnt == 9, "R3 nine writes", wcnt, 9);
        check(rcount_o == 0, "R9 no reads", rcount_o, 0);

        // busy at start, status all clear (R4 R11 R12)
        defaults(); auto_mode = 0; fixed_msr = 8'h00;
        exp_cmd[0] = 8'h77;
        run(2, 1);
        check(err_o == 1, "R4 busy code", err_o, 1);
        check(wcnt == 0, "R4 no writes", wcnt, 0);
        check(op_o == 8'h01, "R11 mode kept", op_o, 8'h01);
        repeat (20) @(negedge clk);
        check(err_o == 1, "R12 err held", err_o, 1);

        // busy at start, direction wrong (R4)
        defaults(); auto_mode = 0; fixed_msr = 8'hC0;
        run(1, 1);
        check(err_o == 1, "R4 wrong direction", err_o, 1);
        check(wcnt == 0 && rcnt == 0, "R4 no transfer", wcnt + rcnt, 0);

        // byte stall costing two timeouts, then success (R5)
        defaults(); stall_idx = 1; stall_left = 340;
        exp_cmd[0] = 8'h0F;
        run(3, 1);
        check(err_o == 0, "R5 retried ok", err_o, 0);
        check(wcnt == 3, "R5 all bytes", wcnt, 3);
        check(rcount_o == 1, "R5 result read", rcount_o, 1);

        // byte stall costing four timeouts (R5)
        defaults(); stall_idx = 1; stall_left = 3000;
        run(3, 1);
        check(err_o == 2, "R5 fatal timeout", err_o, 2);
        check(wcnt == 1, "R5 one byte", wcnt, 1);
        check(done_cyc - last_wr_cyc >= 600 && done_cyc - last_wr_cyc <= 700,
              "R5 four windows", done_cyc - last_wr_cyc, 656);

        // output wait expires (R6)
        defaults(); out_dly = 2000;
        run(2, 2);
        check(err_o == 2, "R6 out timeout", err_o, 2);
        check(rcnt == 0, "R6 no reads", rcnt, 0);
        check(done_cyc - last_wr_cyc >= 500 && done_cyc - last_wr_cyc < 560,
              "R6 window", done_cyc - last_wr_cyc, 514);

        // ready-for-output for one edge only (R7)
        defaults(); out_dly = 40; glitch = 1;
        run(2, 2);
        check(err_o == 1, "R7 result start busy", err_o, 1);
        check(rcnt == 0, "R7 no reads", rcnt, 0);

        // controller drops busy after first result (R8)
        defaults(); prem_at = 1;
        run(1, 3);
        check(err_o == 3, "R8 premature", err_o, 3);
        check(rcount_o == 1, "R8 count", rcount_o, 1);
        check(res_o[7:0] == res_vals[0], "R8 first byte", res_o[7:0], res_vals[0]);

        // full result buffer with slow tick (R9 R10)
        defaults(); tick_div = 3;
        for (int i = 0; i < MAX_RES; i++) res_vals[i] = 8'(8'hC3 ^ (i * 29));
        run(2, 10);
        check(err_o == 0, "R9 slow tick err", err_o, 0);
        check(rcount_o == 10, "R9 ten reads", rcount_o, 10);
        for (int i = 0; i < MAX_RES; i++)
            check(res_o[8*i +: 8] == res_vals[i], "R9 buffer byte", res_o[8*i +: 8], res_vals[i]);
        check(done_cyc - last_rd_cyc >= 3*SETTLE - 3, "R10 slow settle", done_cyc - last_rd_cyc, 3*SETTLE);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule